// File: doc/BRIEF.md
# Stereo Digital Audio Serial Port (Slave)

This block is the slave side of a stereo digital audio serial link. A receive path turns the serial data line into parallel left and right words. A transmit path turns a parallel left/right pair back into a serial stream. The external master supplies the bit clock and the word clock. The block samples both, together with the data line, on its own faster system clock, and finds the bit-clock edges by comparing successive samples.

A single framing engine serves two kinds of framing:
- Two-phase framing, where the word clock has a 50% duty cycle and its level marks the channel.
- Pulse-sync framing, where a short word-clock pulse opens a fixed 16+16 bit frame.

Five static inputs set the format: framing kind, word-clock polarity, bit-clock polarity, a one-bit MSB delay (a delay of one gives I2S timing, zero gives left-justified timing) and word size (16 or 18 bits).

Received words are presented as 18-bit values together with a one-cycle valid strobe. A transmit pair is loaded with a strobe and takes effect at the next frame start. A pulse on the overrun output reports a frame start that found no fresh pair.

Top module: `audio_serial_port`

## Requirements
- R1: After reset the received words are 0, the valid strobe and the overrun output are low, and the serial output is 0.
- R2: In two-phase framing, with word-clock invert 0 the low word-clock phase carries the left word and the high phase the right word. With invert 1 the phases swap.
- R3: With bit-clock invert 0, data is sampled on the rising bit-clock edge and launched on the falling edge. With invert 1 both edges swap.
- R4: In two-phase framing, with MSB delay 0 the MSB is on the first sampling edge after a word-clock transition. With delay 1 it is on the second sampling edge.
- R5: Word size 1 takes 18 bits per word, MSB first. Word size 0 takes 16 bits, placed in output bits 17:2 with bits 1:0 cleared. Serial bits after the last bit of a word are ignored.
- R6: The valid strobe is high for one system clock per frame, after the right word's last bit. Both received words update only in that cycle.
- R7: In pulse-sync framing, the frame starts on the falling word-clock edge when word-clock invert is 0 and on the rising edge when it is 1. The MSB of 16 left bits is on that sampling edge, and 16 right bits follow at once. MSB delay and word size have no effect in this mode.
- R8: The serial output sends each transmit word MSB first, in the bit positions given by R4, R5 and R7, using the launch edge. Outside those positions it drives 0. A 16-bit word sends input bits 17:2.
- R9: A pair presented with the load strobe is captured, and it is sent starting at the next frame start. Without a new load, the previous pair is sent again.
- R10: At a frame start with no load since the previous frame start, the overrun output pulses high for one system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than the bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pcm_mode_i | input | 1 | 1 = pulse-sync framing, 0 = two-phase framing |
| wclk_inv_i | input | 1 | Word-clock polarity select |
| bclk_inv_i | input | 1 | Bit-clock edge select |
| msb_delay_i | input | 1 | MSB delay of one bit (two-phase framing only) |
| word18_i | input | 1 | 1 = 18-bit words, 0 = 16-bit words |
| bclk_i | input | 1 | Serial bit clock from the master |
| wclk_i | input | 1 | Word clock / frame sync from the master |
| sdin_i | input | 1 | Serial receive data |
| sdout_o | output | 1 | Serial transmit data |
| rx_left_o | output | WORD_W | Received left word |
| rx_right_o | output | WORD_W | Received right word |
| rx_valid_o | output | 1 | One-cycle strobe when a received pair is ready |
| tx_load_i | input | 1 | Load strobe for the transmit pair |
| tx_left_i | input | WORD_W | Transmit left word |
| tx_right_i | input | WORD_W | Transmit right word |
| tx_overrun_o | output | 1 | Pulse at a frame start that found no new pair |

## Verification
The bench builds the block with its default parameters: 18-bit full words, 16-bit short words, 16-bit pulse-sync slots and two synchronizer stages. With these values, both word sizes, the left-alignment of short words and both framing kinds can be reached. The bench's master keeps each bit-clock phase 8 system clocks long and uses 20-bit slots in two-phase framing. This leaves random junk bits past every word to exercise the discard rule. Every combination of the polarity, delay and size controls is covered, together with back-to-back frames that skip a load to trigger overrun.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef struct packed {
    logic pcm;
    logic wclk_inv;
    logic msb_dly;
    logic word18;
  } asp_fmt_t;
endpackage

// File: rtl/asp_sync_edge.sv
module asp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  input  logic wclk_i,
  input  logic sdin_i,
  input  logic bclk_inv_i,
  output logic smp_stb_o,
  output logic lch_stb_o,
  output logic wclk_o,
  output logic sdin_o
);
  localparam int CW = 3 * STAGES;

  logic [CW-1:0] chain_q;
  logic          bclk_prev_q;
  logic          bclk_s, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q     <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      chain_q     <= {chain_q[CW-4:0], sdin_i, wclk_i, bclk_i};
      bclk_prev_q <= bclk_s;
    end
  end

  assign bclk_s    = chain_q[CW-3];
  assign wclk_o    = chain_q[CW-2];
  assign sdin_o    = chain_q[CW-1];
  assign rise      = bclk_s & ~bclk_prev_q;
  assign fall      = ~bclk_s & bclk_prev_q;
  assign smp_stb_o = bclk_inv_i ? fall : rise;
  assign lch_stb_o = bclk_inv_i ? rise : fall;

  AST_EDGE_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_stb_o |=> !smp_stb_o); // R3
endmodule

// File: rtl/asp_slot.sv
module asp_slot
  import asp_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int SHORT_W = 16,
  parameter int PCM_W   = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     stb_i,
  input  logic     wclk_i,
  input  asp_fmt_t fmt_i,
  output logic     frame_o,
  output logic     chan_o,
  output int       idx_o,
  output int       nbits_o,
  output logic     in_word_o
);
  localparam int POS_W = $clog2(2 * PCM_W + WORD_W) + 1;
  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic             wclk_q, chan_q, trig;
  logic [POS_W-1:0] pos_q, cur;
  int               span;

  // pulse framing restarts only on the selected edge
  assign trig = stb_i && (wclk_i != wclk_q) && (!fmt_i.pcm || (wclk_i == fmt_i.wclk_inv));

  always_comb begin
    cur       = trig ? '0 : ((pos_q == POS_MAX) ? pos_q : pos_q + POS_W'(1));
    chan_o    = trig ? (wclk_i ^ fmt_i.wclk_inv) : chan_q;
    nbits_o   = fmt_i.pcm ? PCM_W : (fmt_i.word18 ? WORD_W : SHORT_W);
    span      = fmt_i.pcm ? 2 * PCM_W : nbits_o;
    idx_o     = int'(cur) - ((!fmt_i.pcm && fmt_i.msb_dly) ? 1 : 0);
    in_word_o = stb_i && (idx_o >= 0) && (idx_o < span);
    frame_o   = trig && (fmt_i.pcm || !chan_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wclk_q <= 1'b0;
      chan_q <= 1'b0;
      pos_q  <= POS_MAX;
    end else if (stb_i) begin
      wclk_q <= wclk_i;
      chan_q <= chan_o;
      pos_q  <= cur;
    end
  end
endmodule

// File: rtl/asp_rx.sv
module asp_rx
  import asp_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int SHORT_W = 16,
  parameter int PCM_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic              wclk_i,
  input  logic              sdin_i,
  input  asp_fmt_t          fmt_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              valid_o
);
  logic              frame, chan, in_word, last_l, last_r;
  int                idx, nbits;
  logic [WORD_W-1:0] sr_q, hold_q, shifted, aligned;

  asp_slot #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .PCM_W(PCM_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (smp_stb_i),
    .wclk_i   (wclk_i),
    .fmt_i    (fmt_i),
    .frame_o  (frame),
    .chan_o   (chan),
    .idx_o    (idx),
    .nbits_o  (nbits),
    .in_word_o(in_word)
  );

  always_comb begin
    shifted = {sr_q[WORD_W-2:0], sdin_i};
    aligned = shifted << (WORD_W - nbits);
    last_l  = fmt_i.pcm ? (idx == PCM_W - 1)     : (!chan && idx == nbits - 1);
    last_r  = fmt_i.pcm ? (idx == 2 * PCM_W - 1) : ( chan && idx == nbits - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      hold_q  <= '0;
      left_o  <= '0;
      right_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (in_word) begin
        sr_q <= shifted;
        if (last_l) hold_q <= aligned;
        if (last_r) begin
          left_o  <= hold_q;
          right_o <= aligned;
          valid_o <= 1'b1;
        end
      end else if (frame) begin
        sr_q <= '0;
      end
    end
  end

  AST_VALID_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o); // R6
  AST_WORDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(left_o) || !$stable(right_o)) |-> valid_o); // R6
  AST_SHORT_PAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !fmt_i.pcm && !fmt_i.word18) |-> (right_o[WORD_W-SHORT_W-1:0] == '0)); // R5
endmodule

// File: rtl/asp_tx.sv
module asp_tx
  import asp_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int SHORT_W = 16,
  parameter int PCM_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lch_stb_i,
  input  logic              wclk_i,
  input  asp_fmt_t          fmt_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  output logic              sdout_o,
  output logic              overrun_o
);
  logic              frame, chan, in_word, loaded_q, bit_d;
  int                idx, nbits, bpos;
  logic [WORD_W-1:0] pend_l_q, pend_r_q, act_l_q, act_r_q, use_l, use_r, word, sh;

  asp_slot #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .PCM_W(PCM_W)) u_slot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stb_i    (lch_stb_i),
    .wclk_i   (wclk_i),
    .fmt_i    (fmt_i),
    .frame_o  (frame),
    .chan_o   (chan),
    .idx_o    (idx),
    .nbits_o  (nbits),
    .in_word_o(in_word)
  );

  always_comb begin
    use_l = (frame && loaded_q) ? pend_l_q : act_l_q;
    use_r = (frame && loaded_q) ? pend_r_q : act_r_q;
    if (fmt_i.pcm) word = (idx < PCM_W) ? use_l : use_r;
    else           word = chan ? use_r : use_l;
    bpos  = !in_word ? 0 : ((fmt_i.pcm && idx >= PCM_W) ? idx - PCM_W : idx);
    sh    = word << bpos;
    bit_d = in_word && sh[WORD_W-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_l_q  <= '0;
      pend_r_q  <= '0;
      act_l_q   <= '0;
      act_r_q   <= '0;
      loaded_q  <= 1'b0;
      sdout_o   <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      overrun_o <= 1'b0;
      if (lch_stb_i) sdout_o <= bit_d;
      if (frame) begin
        overrun_o <= !loaded_q;
        act_l_q   <= use_l;
        act_r_q   <= use_r;
        loaded_q  <= 1'b0;
      end
      if (load_i) begin
        pend_l_q <= left_i;
        pend_r_q <= right_i;
        loaded_q <= 1'b1;
      end
    end
  end

  AST_SDOUT_LAUNCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdout_o) |-> $past(lch_stb_i)); // R8
  AST_OVR_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(lch_stb_i)); // R10
  AST_OVR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o); // R10
endmodule

// File: rtl/audio_serial_port.sv
module audio_serial_port
  import asp_pkg::*;
#(
  parameter int WORD_W      = 18,
  parameter int SHORT_W     = 16,
  parameter int PCM_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pcm_mode_i,
  input  logic              wclk_inv_i,
  input  logic              bclk_inv_i,
  input  logic              msb_delay_i,
  input  logic              word18_i,
  input  logic              bclk_i,
  input  logic              wclk_i,
  input  logic              sdin_i,
  output logic              sdout_o,
  output logic [WORD_W-1:0] rx_left_o,
  output logic [WORD_W-1:0] rx_right_o,
  output logic              rx_valid_o,
  input  logic              tx_load_i,
  input  logic [WORD_W-1:0] tx_left_i,
  input  logic [WORD_W-1:0] tx_right_i,
  output logic              tx_overrun_o
);
  asp_fmt_t fmt;
  logic     smp_stb, lch_stb, wclk_s, sdin_s;

  assign fmt = '{pcm: pcm_mode_i, wclk_inv: wclk_inv_i, msb_dly: msb_delay_i, word18: word18_i};

  asp_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bclk_i    (bclk_i),
    .wclk_i    (wclk_i),
    .sdin_i    (sdin_i),
    .bclk_inv_i(bclk_inv_i),
    .smp_stb_o (smp_stb),
    .lch_stb_o (lch_stb),
    .wclk_o    (wclk_s),
    .sdin_o    (sdin_s)
  );

  asp_rx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .PCM_W(PCM_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .smp_stb_i(smp_stb),
    .wclk_i   (wclk_s),
    .sdin_i   (sdin_s),
    .fmt_i    (fmt),
    .left_o   (rx_left_o),
    .right_o  (rx_right_o),
    .valid_o  (rx_valid_o)
  );

  asp_tx #(.WORD_W(WORD_W), .SHORT_W(SHORT_W), .PCM_W(PCM_W)) u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lch_stb_i(lch_stb),
    .wclk_i   (wclk_s),
    .fmt_i    (fmt),
    .load_i   (tx_load_i),
    .left_i   (tx_left_i),
    .right_i  (tx_right_i),
    .sdout_o  (sdout_o),
    .overrun_o(tx_overrun_o)
  );
endmodule

// File: tb/tb_audio_serial_port.sv
module tb_audio_serial_port;
  localparam int H    = 8;
  localparam int SLOT = 20;
  localparam int PFR  = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_pcm = 0, c_winv = 0, c_binv = 0, c_dly = 0, c_w18 = 0;
  logic b = 0, w = 0, d = 0;
  logic tx_load = 0;
  logic [17:0] tx_l = '0, tx_r = '0;
  logic sdout, rx_valid, ovr;
  logic [17:0] rx_l, rx_r;

  int n_chk = 0, n_fail = 0;
  int vcnt = 0, ocnt = 0;
  logic [17:0] got_l, got_r;
  logic pend = 0;
  logic [17:0] pend_l = '0, pend_r = '0, act_l = '0, act_r = '0;

  always #5 clk = ~clk;

  audio_serial_port dut (
    .clk_i(clk), .rst_ni(rst_n), .pcm_mode_i(c_pcm), .wclk_inv_i(c_winv),
    .bclk_inv_i(c_binv), .msb_delay_i(c_dly), .word18_i(c_w18),
    .bclk_i(b), .wclk_i(w), .sdin_i(d), .sdout_o(sdout),
    .rx_left_o(rx_l), .rx_right_o(rx_r), .rx_valid_o(rx_valid),
    .tx_load_i(tx_load), .tx_left_i(tx_l), .tx_right_i(tx_r), .tx_overrun_o(ovr)
  );

  always @(negedge clk) begin
    if (rx_valid) begin vcnt++; got_l = rx_l; got_r = rx_r; end
    if (ovr) ocnt++;
  end

  function automatic logic [17:0] expw(input logic [17:0] v, input logic short_w);
    return short_w ? {v[17:2], 2'b00} : v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bitp(input logic wl, input logic dv, output logic so);
    b = c_binv;          // launch level
    w = wl;
    d = dv;
    repeat (H) @(negedge clk);
    b = ~c_binv;         // sample level
    so = sdout;
    repeat (H) @(negedge clk);
  endtask

  task automatic preamble();
    logic so;
    for (int i = 0; i < 4; i++) bitp(~c_winv, 1'b0, so);
  endtask

  task automatic set_cfg(input logic p, input logic wi, input logic bi, input logic dl, input logic ws);
    @(negedge clk);
    c_pcm = p; c_winv = wi; c_binv = bi; c_dly = dl; c_w18 = ws;
    preamble();
  endtask

  task automatic frame(input logic [17:0] rl, input logic [17:0] rr, input logic do_load,
                       input logic [17:0] tl, input logic [17:0] tr);
    logic so, dv, short_w, exp_ovr;
    logic [63:0] got_s, exp_s;
    int nb, i;
    string tag;
    got_s = '0; exp_s = '0;
    if (do_load) begin
      @(negedge clk);
      tx_load = 1; tx_l = tl; tx_r = tr;
      @(negedge clk);
      tx_load = 0; pend = 1; pend_l = tl; pend_r = tr;
    end
    exp_ovr = !pend;                      // R10
    if (pend) begin act_l = pend_l; act_r = pend_r; end
    pend = 0;
    vcnt = 0; ocnt = 0;
    short_w = c_pcm || !c_w18;
    nb = short_w ? 16 : 18;
    if (!c_pcm) begin
      for (int ch = 0; ch < 2; ch++) begin
        for (int p = 0; p < SLOT; p++) begin
          i = p - int'(c_dly);
          dv = (i >= 0 && i < nb) ? (ch ? rr[17-i] : rl[17-i]) : 1'($urandom);
          bitp(ch ? ~c_winv : c_winv, dv, so);
          got_s = {got_s[62:0], so};
          exp_s = {exp_s[62:0], (i >= 0 && i < nb) ? (ch ? act_r[17-i] : act_l[17-i]) : 1'b0};
        end
      end
      tag = "R2 R3 R4 R5";
    end else begin
      for (int p = 0; p < PFR; p++) begin
        if (p < 16)      dv = rl[17-p];
        else if (p < 32) dv = rr[17-(p-16)];
        else             dv = 1'($urandom);
        bitp((p == 0) ? c_winv : ~c_winv, dv, so);
        got_s = {got_s[62:0], so};
        exp_s = {exp_s[62:0], (p < 16) ? act_l[17-p] : (p < 32) ? act_r[17-(p-16)] : 1'b0};
      end
      tag = "R7 R3";
    end
    chk(vcnt == 1, "R6 valid count", 64'(vcnt), 64'd1);
    chk(got_l == expw(rl, short_w), {tag, " rx left"}, 64'(got_l), 64'(expw(rl, short_w)));
    chk(got_r == expw(rr, short_w), {tag, " rx right"}, 64'(got_r), 64'(expw(rr, short_w)));
    chk(got_s == exp_s, c_pcm ? "R7 R8 R9 tx stream" : "R8 R9 tx stream", got_s, exp_s);
    chk(ocnt == int'(exp_ovr), "R10 overrun", 64'(ocnt), 64'(exp_ovr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R6 watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [4:0] rc;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rx_l == 0 && rx_r == 0, "R1 reset words", {rx_l, rx_r}, 64'd0);
    chk(!rx_valid && !ovr && !sdout, "R1 reset flags", {rx_valid, ovr, sdout}, 64'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // all two-phase combinations
    for (int k = 0; k < 16; k++) begin
      set_cfg(0, k[0], k[1], k[2], k[3]);
      frame(18'(($urandom)), 18'(($urandom)), 1, 18'(($urandom)), 18'(($urandom)));
    end
    // extremes
    set_cfg(0, 0, 0, 1, 1);
    frame(18'h3FFFF, 18'h00000, 1, 18'h00000, 18'h3FFFF);
    frame(18'h20001, 18'h1FFFE, 1, 18'h2AAAA, 18'h15555);
    // back-to-back without load: overrun, pair repeats (R9 R10)
    frame(18'h0F0F0, 18'h30303, 0, 18'h0, 18'h0);
    frame(18'h12345, 18'h2ABCD, 1, 18'h3C3C3, 18'h01234);

    // pulse-sync framing, delay and size randomised (R7)
    for (int k = 0; k < 4; k++) begin
      set_cfg(1, k[0], k[1], 1'($urandom), 1'($urandom));
      frame(18'(($urandom)), 18'(($urandom)), 1, 18'(($urandom)), 18'(($urandom)));
    end
    frame(18'h3FFFF, 18'h0000F, 0, 18'h0, 18'h0);

    // random mix
    for (int k = 0; k < 30; k++) begin
      rc = 5'($urandom);
      set_cfg(rc[4] & rc[3], rc[0], rc[1], rc[2], rc[3] ^ rc[4]);
      frame(18'(($urandom)), 18'(($urandom)), ($urandom % 4) != 0,
            18'(($urandom)), 18'(($urandom)));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule